// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `W` bits and returns their full `2W`-bit product. It does not add one partial product for each multiplier bit. The multiplier is recoded into signed radix-4 digits, and each digit covers two bits. In each clock cycle the block forms one digit multiple of the multiplicand (0, ±x or ±2x), sign-extends it to the product width, shifts it to the weight of its digit and adds it into an accumulator. A run takes ceil((W+1)/2) cycles.

To use it, a client presents `x` and `y` with a one-cycle `start` while `busy` is low. The block captures both operands, raises `busy` for the length of the run, and pulses `done` for one cycle when the product is final. The product stays on `product` until the next accepted start.

Top module: `radix4_mult`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, `busy` and `done` go low and `product` goes to zero.
- R2: Digit k is recoded from the triplet {y[2k+1], y[2k], y[2k-1]}. y[-1] is taken as 0 and bits above W-1 are copies of y[W-1]. The mapping is: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1.
- R3: For every pair of signed W-bit operands, `product` at `done` equals x·y as a 2W-bit two's-complement value. This includes the most negative operands.
- R4: `done` is high for exactly one cycle. It rises STEPS = ceil((W+1)/2) clock edges after the edge that accepted `start`.
- R5: `busy` is high in every cycle from the accepting edge until `done` rises, and it is low in the `done` cycle.
- R6: A `start` pulse while `busy` is high is ignored. Operand changes at that time alter neither the result nor the timing of the run in progress.
- R7: While the block is idle and `start` is low, `product` holds its last value, even when `x` and `y` change.
- R8: With W = 6, x = 25 and y = -18 give -450 (0xE3E). The digits from least to most significant are -2, 0, -1, 0.
- R9: Negative digit multiples are formed as invert-plus-one of x or of x shifted left by one. Each multiple is sign-extended to 2W bits before it is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication; honoured only while idle |
| x | input | W | Signed multiplicand |
| y | input | W | Signed multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: product is final |
| product | output | 2W | Signed product |

## Verification
The hardest case to reach from the ports is a run that carries a +2 or -2 digit into the upper groups while new start requests arrive with different operands. Only the sign-padding and the final-weight shift then decide whether the result survives. The stimulus sweeps every operand pair. On alternate pairs it drives `start` again during the busy window with altered `x` and `y`, stopping one edge before completion, so that every triplet value meets the ignored-start path. The most negative multiplicand and multiplier are part of the sweep and are also run as directed cases.

// File: rtl/r4m_pkg.sv
// Shared types for the radix-4 Booth multiplier.
// Assumes: the digit set is the signed radix-4 set {-2,-1,0,+1,+2}.
package r4m_pkg;

    // Recoded digit applied to the multiplicand in one step
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_P1   = 3'd1,
        DIG_P2   = 3'd2,
        DIG_M1   = 3'd3,
        DIG_M2   = 3'd4
    } r4_digit_e;

endpackage

// File: rtl/r4m_recoder.sv
// Maps one overlapping multiplier triplet {hi, mid, lo} to a signed digit.
// Assumes: lo is the bit below the pair (0 for the lowest pair).
module r4m_recoder
    import r4m_pkg::*;
(
    input  logic [2:0] trip,
    output r4_digit_e  dig
);

    // Purpose: triplet-to-digit lookup
    always_comb begin
        unique case (trip)
            3'b001, 3'b010: dig = DIG_P1;
            3'b011:         dig = DIG_P2;
            3'b100:         dig = DIG_M2;
            3'b101, 3'b110: dig = DIG_M1;
            default:        dig = DIG_ZERO;
        endcase
    end

endmodule

// File: rtl/r4m_ppgen.sv
// Forms one digit multiple of the multiplicand, sign-extended to PW bits.
// Doubling is a left shift; negation is invert-plus-one.
// Assumes: PW > W so that 2x fits without loss.
module r4m_ppgen
    import r4m_pkg::*;
#(
    parameter int W  = 6,
    parameter int PW = 2 * W
) (
    input  logic [W-1:0]  x,
    input  r4_digit_e     dig,
    output logic [PW-1:0] pp
);

    logic [PW-1:0] x_ext;
    logic [PW-1:0] mag;
    logic          dbl;
    logic          neg;

    // Purpose: sign extension of the multiplicand to product width
    always_comb x_ext = {{(PW-W){x[W-1]}}, x};

    // Purpose: decode magnitude and sign selection from the digit
    always_comb begin
        dbl = (dig == DIG_P2) || (dig == DIG_M2);
        neg = (dig == DIG_M1) || (dig == DIG_M2);
    end

    // Purpose: build the signed multiple, or zero
    always_comb begin
        mag = dbl ? (x_ext << 1) : x_ext;
        if (dig == DIG_ZERO)
            pp = '0;
        else if (neg)
            pp = ~mag + PW'(1);
        else
            pp = mag;
    end

endmodule

// File: rtl/r4m_seq.sv
// Step sequencer: accepts start while idle, counts STEPS cycles,
// then pulses done for one cycle.
// Assumes: start is ignored whenever busy is high.
module r4m_seq #(
    parameter int STEPS = 4,
    parameter int SW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic [SW-1:0] step
);

    logic last;

    // Purpose: accept only when idle; flag the final step
    always_comb begin
        load = start && !busy;
        last = (step == SW'(STEPS - 1));
    end

    // Purpose: busy/done/step state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            step <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                step <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step <= step + SW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/radix4_mult.sv
// Radix-4 Booth sequential signed multiplier.
// One recoded digit per cycle is added, at its weight, into a 2W-bit
// accumulator that doubles as the product output.
// Assumes: operands are captured on the accepting edge; product is valid
// from the done pulse until the next accepted start.
module radix4_mult
    import r4m_pkg::*;
#(
    parameter int W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);

    localparam int PW    = 2 * W;
    localparam int STEPS = (W + 2) / 2;
    localparam int YW    = 2 * STEPS;
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [W-1:0]  x_q;
    logic [YW:0]   y_q;
    logic [PW-1:0] acc;
    logic [2:0]    trip_w;
    r4_digit_e     dig_w;
    logic [PW-1:0] pp_w;
    logic          load_w;
    logic [SW-1:0] step_w;

    r4m_seq #(.STEPS(STEPS), .SW(SW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load_w),
        .step  (step_w)
    );

    // Purpose: current triplet is the low end of the shifting multiplier
    always_comb trip_w = y_q[2:0];

    r4m_recoder u_rec (
        .trip (trip_w),
        .dig  (dig_w)
    );

    r4m_ppgen #(.W(W), .PW(PW)) u_pp (
        .x   (x_q),
        .dig (dig_w),
        .pp  (pp_w)
    );

    // Purpose: operand capture, multiplier shift and accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            acc <= '0;
        end else if (load_w) begin
            x_q <= x;
            y_q <= {{(YW-W){y[W-1]}}, y, 1'b0};
            acc <= '0;
        end else if (busy) begin
            acc <= acc + (pp_w << {step_w, 1'b0});
            y_q <= {{2{y_q[YW]}}, y_q[YW:2]};
        end
    end

    // Purpose: expose the accumulator as the product
    always_comb product = acc;

endmodule

// File: rtl/radix4_mult_chk.sv
// Property checker for radix4_mult, attached by bind.
// Assumes: the done pulse follows exactly STEPS busy cycles.
module radix4_mult_chk
    import r4m_pkg::*;
#(
    parameter int W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product,
    input logic [2:0]     trip,
    input r4_digit_e      dig,
    input logic [W-1:0]   x_q
);

    localparam int STEPS = (W + 2) / 2;

    logic [7:0] run_cnt;

    // Purpose: count consecutive busy cycles for the latency check
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_cnt <= '0;
        else                 run_cnt <= run_cnt + 8'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && product == '0));

    // R2
    digit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (trip == 3'b000 || trip == 3'b111)) |-> dig == DIG_ZERO);

    // R2
    digit_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trip == 3'b011) |-> dig == DIG_P2);

    // R2
    digit_negdbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trip == 3'b100) |-> dig == DIG_M2);

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_cnt == 8'(STEPS));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(x_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind radix4_mult radix4_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .trip    (trip_w),
    .dig     (dig_w),
    .x_q     (x_q)
);

// File: tb/radix4_mult_test.sv
module radix4_mult_test;

    localparam int W          = 6;
    localparam int PW         = 2 * W;
    localparam int STEPS      = (W + 2) / 2;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  x = '0;
    logic [W-1:0]  y = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;

    radix4_mult #(.W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .x       (x),
        .y       (y),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // One multiplication; poke=1 re-drives start with other operands while busy
    task automatic run_op(input int a, input int b, input bit poke, input string tag);
        logic [PW-1:0] expv;
        int  n;
        bit  busy_ok;
        expv = PW'(a * b);
        @(negedge clk);
        x = W'(a); y = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0; n = 0; busy_ok = 1'b1;
        while (!done && n < 4 * STEPS) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && (n + 1 < STEPS)) begin
                start = 1'b1; x = ~x; y = y + W'(1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk({tag, " R4 latency"}, n, STEPS);
        chk({tag, " R5 busy window"}, (busy_ok && !busy) ? 1 : 0, 1);
        chk({tag, " R3 product"}, product, expv);
    endtask

    initial begin : watchdog
        repeat (MAXC) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", MAXC, MAXC);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [PW-1:0] held;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 product", product, 0);
        rst_n = 1'b1;

        // R8: worked example, digits -2, 0, -1, 0
        run_op(25, -18, 1'b0, "R8");
        chk("R8 value", product, 64'hE3E);

        // R2: multipliers isolating each triplet class
        run_op(7, 1, 1'b0, "R2 +1");
        run_op(7, 2, 1'b0, "R2 -2/+1");
        run_op(7, 3, 1'b0, "R2 -1/+1");
        run_op(-9, 6, 1'b0, "R2 -2/+2");
        run_op(-9, -1, 1'b0, "R2 111");

        // R9: most negative operands, sign extension of 2x multiples
        run_op(-32, -32, 1'b0, "R9");
        run_op(-32, 31, 1'b0, "R9");
        run_op(31, -32, 1'b0, "R9");

        // R6: starts during busy with altered operands
        run_op(-27, 19, 1'b1, "R6");
        run_op(13, -32, 1'b1, "R6");

        // R7: idle hold while operands wander
        held = product;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            x = W'(i * 11); y = W'(~i);
        end
        chk("R7 hold", product, held);
        chk("R7 idle", busy, 0);

        // R3 exhaustive sweep, alternate entries also poke start (R6)
        for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
            for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++) begin
                run_op(a, b, bit'((a + b) & 1), "R3 sweep");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule